// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator

This block drives the gate controls of a two-phase synchronous buck power stage. Each phase has its own counter ramp. The two ramps run half a switching period apart. Each ramp is compared with a digital control word that the block receives already digitized. When a ramp is below the control word, the high-side gate of that phase is on. When it is not, the low-side gate is on. A programmable number of dead cycles with both gates off separates every change from one gate to the other.

The on-time is limited to three quarters of the period. Phase 2 can be switched off, which holds both of its gates low while its ramp keeps counting. The block emits a one-cycle strobe at the start of each phase-1 cycle. The period is captured while the block is idle. Each phase captures the control word only at its own cycle boundary, so on-times never glitch in the middle of a cycle.

Top module: `pwm2ph_gen`

## Requirements
- R1: Each ramp counts 0, 1, ..., P-1 and then wraps to 0, where P is the captured period (P >= 4). When running starts, the phase-1 ramp begins at 0 and the phase-2 ramp begins at floor(P/2).
- R2: The switching request of a phase is 1 while its ramp value is below that phase's effective duty. The request is applied to the gate pair one clock later, through the dead-time logic of R5.
- R3: The effective duty is the smaller of the captured control word and floor(3*P/4). A high-side on-run therefore never exceeds floor(3*P/4) cycles.
- R4: While phase-2 enable is 0, both phase-2 gates are low and the phase-2 ramp keeps counting. When phase 2 is enabled again, it starts from a dead-time wait, as after idle.
- R5: When the switching request of a phase changes, both gates of that phase are off for D clock cycles, where D is the dead-time word. The gate for the new request then turns on. With D = 0, the gate for the new request turns on one cycle after the change. The high-side and low-side gates of a phase are never high together.
- R6: Each phase captures the control word in the clock cycle where its ramp equals P-1, so that the value applies from count 0. The phases also capture it in every idle cycle. Control-word changes at any other time have no effect.
- R7: While run enable is 0, all four gates and the strobe are low, the ramps are preset as in R1, and the dead-time logic restarts with a D-cycle wait in which both gates are off.
- R8: The strobe is high in exactly those running cycles in which the phase-1 ramp is 0.
- R9: The period word is captured in every idle cycle. Changes to it while running have no effect until the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run enable |
| ph2_en_i | input | 1 | Phase-2 enable |
| duty_i | input | CNT_W | Control word (on-time in cycles) |
| period_i | input | CNT_W | Switching period in cycles |
| dead_i | input | DT_W | Dead time in cycles |
| hs1_o | output | 1 | Phase-1 high-side gate |
| ls1_o | output | 1 | Phase-1 low-side gate |
| hs2_o | output | 1 | Phase-2 high-side gate |
| ls2_o | output | 1 | Phase-2 low-side gate |
| sync_o | output | 1 | Phase-1 cycle-start strobe |

## Verification
The bench covers these corner cases:

- **Duty near the limit.** It drives a control word far above the limit. A missing clamp would leave the high side on for the whole period. It also drives an odd period, where an off-by-one in the floor of 3P/4 or in the half-period preset would shift edges by a cycle.
- **Mid-cycle changes.** It changes the control word and the period in the middle of a cycle. A design that used either one live would move edges inside the cycle.
- **Dead time.** It uses dead times of zero and several cycles. A wrong dead count would shorten or stretch the gap, or let the gates overlap.
- **Phase-2 switching and restarts.** It toggles phase 2 off and on and restarts the run. A design that reset the phase-2 ramp, or skipped the dead-time wait, would lose the half-period offset or drive a gate straight after enable.

// File: rtl/pwm2ph_pkg.sv
package pwm2ph_pkg;
  localparam int unsigned DEF_CNT_W = 8;
  localparam int unsigned DEF_DT_W  = 4;

  // floor(3*p/4): the on-time ceiling
  function automatic logic [31:0] duty_ceil(input logic [31:0] p);
    return (p * 32'd3) >> 2;
  endfunction
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int unsigned CNT_W      = 8,
  parameter bit          HALF_START = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             req_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, duty_q, eff;
  logic             last;
  logic [CNT_W-1:0] start_val;

  assign start_val = HALF_START ? (per_i >> 1) : '0;
  assign last      = (cnt_q == per_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= start_val;
      duty_q <= duty_i;
    end else begin
      if (last) duty_q <= duty_i;
      cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign eff    = (duty_q < lim_i) ? duty_q : lim_i;
  assign req_o  = (cnt_q < eff);
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic            req_i,
  output logic            hs_o,
  output logic            ls_o
);
  logic            lvl_q;
  logic [DT_W-1:0] wait_q;
  logic            settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      wait_q <= '0;
    end else if (!en_i) begin
      lvl_q  <= 1'b0;
      wait_q <= dead_i;
    end else if (req_i != lvl_q) begin
      lvl_q  <= req_i;
      wait_q <= dead_i;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - DT_W'(1);
    end
  end

  assign settled = en_i && (wait_q == '0);
  assign hs_o    = settled &&  lvl_q;
  assign ls_o    = settled && !lvl_q;
endmodule

// File: rtl/pwm2ph_gen.sv
module pwm2ph_gen
  import pwm2ph_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned DT_W  = DEF_DT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ph2_en_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             hs1_o,
  output logic             ls1_o,
  output logic             hs2_o,
  output logic             ls2_o,
  output logic             sync_o
);
  localparam int unsigned NPH = 2;

  logic [CNT_W-1:0] per_q, per_eff, lim;
  logic [NPH-1:0]   req, zero, en, hs, ls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     per_q <= '0;
    else if (!run_i) per_q <= period_i;
  end

  assign per_eff = run_i ? per_q : period_i;
  assign lim     = CNT_W'(duty_ceil(32'(per_eff)));
  assign en      = {run_i & ph2_en_i, run_i};

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    pwm_ramp #(.CNT_W(CNT_W), .HALF_START(g == 1)) u_ramp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .per_i  (per_eff),
      .lim_i  (lim),
      .duty_i (duty_i),
      .req_o  (req[g]),
      .zero_o (zero[g])
    );
    pwm_deadband #(.DT_W(DT_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[g]),
      .dead_i (dead_i),
      .req_i  (req[g]),
      .hs_o   (hs[g]),
      .ls_o   (ls[g])
    );
  end

  assign hs1_o  = hs[0];
  assign ls1_o  = ls[0];
  assign hs2_o  = hs[1];
  assign ls2_o  = ls[1];
  assign sync_o = run_i & zero[0];
endmodule

// File: rtl/pwm2ph_gen_chk.sv
module pwm2ph_gen_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             ph2_en_i,
  input logic [CNT_W-1:0] duty_i,
  input logic [CNT_W-1:0] period_i,
  input logic [DT_W-1:0]  dead_i,
  input logic             hs1_o,
  input logic             ls1_o,
  input logic             hs2_o,
  input logic             ls2_o,
  input logic             sync_o
);
  logic [15:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_run <= '0;
    else if (hs1_o) hi_run <= hi_run + 16'd1;
    else            hi_run <= '0;
  end

  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_o && ls1_o) && !(hs2_o && ls2_o));

  a_r5_gap_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hs1_o) && dead_i != '0) |-> !ls1_o);

  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !(hs1_o || ls1_o || hs2_o || ls2_o || sync_o));

  a_r4_ph2_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph2_en_i |-> !(hs2_o || ls2_o));

  a_r8_sync_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  a_r3_on_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(hi_run) * 32'd4) <= (32'(period_i) * 32'd3));
endmodule

bind pwm2ph_gen pwm2ph_gen_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (.*);

// File: tb/sim_pwm2ph_gen.sv
`timescale 1ns/1ps
module sim_pwm2ph_gen;
  localparam int CW = 8;
  localparam int DW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, ph2 = 1'b1;
  logic [CW-1:0] duty = '0, period = 8'd16;
  logic [DW-1:0] dead = 4'd2;
  logic hs1, ls1, hs2, ls2, sync;

  always #10 clk = ~clk;

  pwm2ph_gen #(.CNT_W(CW), .DT_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .ph2_en_i(ph2),
    .duty_i(duty), .period_i(period), .dead_i(dead),
    .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2), .sync_o(sync));

  int checks = 0, errors = 0;
  string cur_req = "R7";
  bit done = 0;

  // reference state, derived from the requirements
  int m_c[2], m_d[2], m_per, m_dc[2];
  bit m_lvl[2];
  logic [4:0] exp_q[$];

  function automatic int ceil_of(int p); return (3 * p) / 4; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_c[k] = 0; m_d[k] = 0; m_lvl[k] = 0; m_dc[k] = 0; end
      m_per = 0;
    end else begin
      int lim, eff; bit rq[2]; bit en[2];
      lim = ceil_of(m_per);
      for (int k = 0; k < 2; k++) begin
        eff = (m_d[k] < lim) ? m_d[k] : lim;
        rq[k] = (m_c[k] < eff);
        en[k] = run && (k == 0 || ph2);
        if (!en[k]) begin m_lvl[k] = 0; m_dc[k] = int'(dead); end
        else if (rq[k] != m_lvl[k]) begin m_lvl[k] = rq[k]; m_dc[k] = int'(dead); end
        else if (m_dc[k] != 0) m_dc[k]--;
      end
      if (!run) begin
        m_per = int'(period);
        m_c[0] = 0; m_c[1] = int'(period) / 2;
        m_d[0] = int'(duty); m_d[1] = int'(duty);
      end else begin
        for (int k = 0; k < 2; k++) begin
          if (m_c[k] == m_per - 1) begin m_d[k] = int'(duty); m_c[k] = 0; end
          else m_c[k]++;
        end
      end
    end
  end

  // driver side of the scoreboard: expected outputs each cycle
  always @(negedge clk) if (rst_n) begin
    bit e1, e2; logic [4:0] e;
    e1 = run && m_dc[0] == 0;
    e2 = run && ph2 && m_dc[1] == 0;
    e = {e1 && m_lvl[0], e1 && !m_lvl[0], e2 && m_lvl[1], e2 && !m_lvl[1], run && m_c[0] == 0};
    exp_q.push_back(e);
  end

  // monitor
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [4:0] e, a;
      e = exp_q.pop_front();
      a = {hs1, ls1, hs2, ls2, sync};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s {hs1,ls1,hs2,ls2,sync} actual=%b expected=%b at %0t", cur_req, a, e, $time);
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(posedge clk); #2; endtask

  initial begin
    cyc(3);
    // reset state: all outputs low (R7)
    checks++;
    if ({hs1, ls1, hs2, ls2, sync} !== 5'b0) begin
      errors++; $display("FAIL R7 reset actual=%b expected=00000", {hs1, ls1, hs2, ls2, sync});
    end
    rst_n = 1'b1;
    cyc(10);
    cur_req = "R1"; duty = 8'd6; run = 1'b1; cyc(60);
    cur_req = "R2"; duty = 8'd10; cyc(40); duty = 8'd0; cyc(40); duty = 8'd3; cyc(40);
    cur_req = "R3"; duty = 8'd255; cyc(50); duty = 8'd12; cyc(40);
    cur_req = "R5"; dead = 4'd0; duty = 8'd7; cyc(40); dead = 4'd3; cyc(40); dead = 4'd1; cyc(30);
    cur_req = "R6";
    for (int i = 0; i < 12; i++) begin duty = 8'(2 + (i * 5) % 13); cyc(3 + i % 4); end
    cur_req = "R4"; ph2 = 1'b0; cyc(40); ph2 = 1'b1; cyc(40);
    cur_req = "R9"; period = 8'd10; cyc(40);
    cur_req = "R7"; run = 1'b0; cyc(5); period = 8'd11; duty = 8'd9; cyc(3);
    cur_req = "R1"; run = 1'b1; cyc(60);
    cur_req = "R3"; duty = 8'd200; cyc(45);
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin run = 1'b0; cyc(2 + i); run = 1'b1; cyc(17 + 3 * i); end
    cur_req = "R7"; run = 1'b0; cyc(10);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule